// File: doc/BRIEF.md
# Dual-Task Register Programming Sequencer

This block is a small command processor that programs and reads back on-chip registers without host involvement. Two identical tasks run side by side, each with its own program pointer, start address and timeout limit. A task fetches 32-bit command words from a shared memory port, executes them, and moves on. It can write a register with a literal taken from the next word, copy a register into memory, stall until a hardware event or shared signal is true, branch on such a condition, or set and clear one of five shared signals that the host can also see.

A host starts a task by pulsing its start input while the task is idle. The task then runs until it reaches a stop command or a stalled wait exceeds its timeout limit. A round-robin arbiter shares the single memory port and the single register port between the two tasks. While one task is stalled on an event, the other keeps running.

Both request ports use valid/ready. Once a request is raised, its valid signal, address, write flag and write data hold steady until ready is seen at a clock edge, and the arbiter keeps the grant on that request for as long as it waits. The memory port allows one read in flight. Its response is a single-cycle `mem_rvalid` pulse that cannot be back-pressured, and no new memory request is issued until that pulse arrives. The register port returns read data in the same cycle as the handshake.

Top module: `dual_task_sequencer`

## Requirements
- R1: After reset, both task enables, both timeout flags and all five shared signals are 0. No memory or register request is raised while both tasks are idle.
- R2: A pulse on `task_start[i]` while task i is idle sets its enable, clears its timeout flag and starts fetching at its `start_addr` slice. A start pulse while the task is enabled is ignored.
- R3: A command word carries its opcode in bits 31:28. Opcode 1 (load) writes the following word to the register whose address is in bits RADDR_W-1:0.
- R4: Opcode 2 (upload) reads the register addressed by bits RADDR_W-1:0 and writes that value to memory at the address held in the low ADDR_W bits of the following word.
- R5: Opcode 0 (stop) clears the task's enable. Opcodes 6 to 15 are skipped, and execution continues with the next word.
- R6: Opcode 3 (pause) stalls the task until the condition in bits 21:16 is true. Bit 21 set selects shared signal bits 18:16; bit 21 clear selects event bits 20:16. The other task keeps executing during the stall.
- R7: Each event is latched: it is set on a rising edge of its input and cleared on a falling edge. An input that is high out of reset and never rises stays unset.
- R8: Opcode 4 (jump) loads the program address from bits ADDR_W-1:0 when its condition (same encoding as R6) is true. Otherwise execution falls through to the next word.
- R9: Opcode 5 drives shared signal number bits 2:0 to the value in bit 8. The result appears on `sig_out`.
- R10: With a nonzero limit L, a pause that stays false for L cycles aborts the task: its enable clears and its timeout flag sets. A limit of 0 waits forever.
- R11: Memory and register requests from the two tasks are granted round-robin. A grant is held while its request stalls, only one memory read is outstanding, and both tasks' results are correct when they run together.
- R12: On both request ports, valid, address, write flag and write data stay stable while valid is high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 2 | Per-task start pulse |
| start_addr | input | 2*ADDR_W | Per-task first command address, task i in slice i |
| tmo_limit | input | 2*TMO_W | Per-task pause timeout in cycles, 0 disables |
| event_in | input | EV_W | Raw event inputs |
| task_en | output | 2 | Per-task enable |
| task_timeout | output | 2 | Per-task timeout flag |
| sig_out | output | 5 | Shared signals |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request ready |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Read data |
| reg_valid | output | 1 | Register request valid |
| reg_ready | input | 1 | Register request ready |
| reg_write | output | 1 | Register request is a write |
| reg_addr | output | RADDR_W | Register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, same cycle |

## Verification
The bench builds the block with ADDR_W=8, RADDR_W=4, TMO_W=8 and EV_W=4. The 8-bit address lets a 256-word memory model hold every program and upload target. The 4-bit register address fits a 16-entry register model, and the 8-bit timeout field makes a 20-cycle abort fit in a short run. The memory and register models can switch to pseudo-random ready, which exercises held grants and stable requests while the two tasks contend.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_TASKS = 2;
  localparam int NUM_SIG   = 5;
  localparam int CMD_W     = 32;
  localparam int OPC_MSB   = 31;
  localparam int OPC_LSB   = 28;
  localparam int CND_MSB   = 21;
  localparam int CND_LSB   = 16;
  localparam int SIG_VBIT  = 8;

  typedef enum logic [3:0] {
    OP_STOP   = 4'd0,
    OP_LOAD   = 4'd1,
    OP_UPLOAD = 4'd2,
    OP_PAUSE  = 4'd3,
    OP_JUMP   = 4'd4,
    OP_SIGNAL = 4'd5
  } opcode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_RSP, S_EXEC, S_FETCH2, S_RSP2,
    S_REGW, S_REGR, S_MEMW, S_PAUSE
  } tstate_e;
endpackage

// File: rtl/seq_event_latch.sv
module seq_event_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_in,
  output logic [W-1:0] ev_flag
);
  logic [W-1:0] prev;
  logic [W-1:0] rise, fall;

  assign rise = ev_in & ~prev;
  assign fall = ~ev_in & prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= '1;
      ev_flag <= '0;
    end else begin
      prev    <= ev_in;
      ev_flag <= rise | (ev_flag & ~fall);
    end
  end
endmodule

// File: rtl/seq_rr_arb.sv
module seq_rr_arb #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          ready,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] sel,
  output logic          any
);
  logic [IW-1:0] prio, lock_idx, pick;
  logic          locked, found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(prio) + k) % N]) begin
        found = 1'b1;
        pick  = IW'((int'(prio) + k) % N);
      end
    end
    sel = locked ? lock_idx : pick;
    any = locked | found;
    gnt = '0;
    if (any) gnt[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio     <= '0;
      locked   <= 1'b0;
      lock_idx <= '0;
    end else if (any && ready) begin
      locked <= 1'b0;
      prio   <= (sel == IW'(N-1)) ? '0 : sel + 1'b1;
    end else if (any) begin
      locked   <= 1'b1;
      lock_idx <= sel;
    end
  end
endmodule

// File: rtl/seq_task.sv
module seq_task
  import seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int RAW  = 8,
  parameter int TW   = 16,
  parameter int EV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [AW-1:0]      start_addr,
  input  logic [TW-1:0]      tmo_limit,
  input  logic [EV_W-1:0]    ev_flag,
  input  logic [NUM_SIG-1:0] sig_in,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [CMD_W-1:0]   mem_wdata,
  input  logic               mem_fire,
  input  logic               rsp_valid,
  input  logic [CMD_W-1:0]   rsp_data,
  output logic               reg_req,
  output logic               reg_we,
  output logic [RAW-1:0]     reg_addr,
  output logic [CMD_W-1:0]   reg_wdata,
  input  logic               reg_fire,
  input  logic [CMD_W-1:0]   reg_rdata,
  output logic               sig_we,
  output logic [2:0]         sig_idx,
  output logic               sig_val,
  output logic               en,
  output logic               tmo_flag
);
  tstate_e          state;
  logic [AW-1:0]    pc;
  logic [CMD_W-1:0] cmd, opnd, rd_val;
  logic [TW-1:0]    cnt;
  logic [3:0]       opc;
  logic             cond;
  logic [7:0]       sig_pad;
  logic [31:0]      ev_pad;

  assign opc = cmd[OPC_MSB:OPC_LSB];

  always_comb begin
    sig_pad = '0;
    sig_pad[NUM_SIG-1:0] = sig_in;
    ev_pad = '0;
    ev_pad[EV_W-1:0] = ev_flag;
    if (cmd[CND_MSB]) cond = sig_pad[cmd[CND_LSB+2:CND_LSB]];
    else              cond = ev_pad[cmd[CND_LSB+4:CND_LSB]];
  end

  always_comb begin
    en        = (state != S_IDLE);
    mem_req   = (state == S_FETCH) || (state == S_FETCH2) || (state == S_MEMW);
    mem_we    = (state == S_MEMW);
    mem_addr  = (state == S_MEMW) ? opnd[AW-1:0] : pc;
    mem_wdata = rd_val;
    reg_req   = (state == S_REGW) || (state == S_REGR);
    reg_we    = (state == S_REGW);
    reg_addr  = cmd[RAW-1:0];
    reg_wdata = opnd;
    sig_we    = (state == S_EXEC) && (opc == OP_SIGNAL);
    sig_idx   = cmd[2:0];
    sig_val   = cmd[SIG_VBIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pc       <= '0;
      cmd      <= '0;
      opnd     <= '0;
      rd_val   <= '0;
      cnt      <= '0;
      tmo_flag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pc       <= start_addr;
          tmo_flag <= 1'b0;
          state    <= S_FETCH;
        end
        S_FETCH: if (mem_fire) begin
          pc    <= pc + 1'b1;
          state <= S_RSP;
        end
        S_RSP: if (rsp_valid) begin
          cmd   <= rsp_data;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (opc)
            OP_STOP:   state <= S_IDLE;
            OP_LOAD,
            OP_UPLOAD: state <= S_FETCH2;
            OP_PAUSE: begin
              cnt   <= '0;
              state <= S_PAUSE;
            end
            OP_JUMP: begin
              if (cond) pc <= cmd[AW-1:0];
              state <= S_FETCH;
            end
            default:   state <= S_FETCH;
          endcase
        end
        S_FETCH2: if (mem_fire) begin
          pc    <= pc + 1'b1;
          state <= S_RSP2;
        end
        S_RSP2: if (rsp_valid) begin
          opnd  <= rsp_data;
          state <= (opc == OP_LOAD) ? S_REGW : S_REGR;
        end
        S_REGW: if (reg_fire) state <= S_FETCH;
        S_REGR: if (reg_fire) begin
          rd_val <= reg_rdata;
          state  <= S_MEMW;
        end
        S_MEMW: if (mem_fire) state <= S_FETCH;
        S_PAUSE: begin
          if (cond) begin
            state <= S_FETCH;
          end else if ((tmo_limit != '0) && (cnt == tmo_limit - TW'(1))) begin
            tmo_flag <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_task_sequencer.sv
module dual_task_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int RADDR_W = 8,
  parameter int TMO_W   = 16,
  parameter int EV_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_TASKS-1:0]          task_start,
  input  logic [NUM_TASKS*ADDR_W-1:0]   start_addr,
  input  logic [NUM_TASKS*TMO_W-1:0]    tmo_limit,
  input  logic [EV_W-1:0]               event_in,
  output logic [NUM_TASKS-1:0]          task_en,
  output logic [NUM_TASKS-1:0]          task_timeout,
  output logic [NUM_SIG-1:0]            sig_out,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic                          mem_write,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [CMD_W-1:0]              mem_wdata,
  input  logic                          mem_rvalid,
  input  logic [CMD_W-1:0]              mem_rdata,
  output logic                          reg_valid,
  input  logic                          reg_ready,
  output logic                          reg_write,
  output logic [RADDR_W-1:0]            reg_addr,
  output logic [CMD_W-1:0]              reg_wdata,
  input  logic [CMD_W-1:0]              reg_rdata
);
  localparam int NT = NUM_TASKS;
  localparam int IW = (NT > 1) ? $clog2(NT) : 1;

  logic [EV_W-1:0]               ev_flag;
  logic [NT-1:0]                 t_mem_req, t_mem_we, t_mem_fire, t_rsp;
  logic [NT-1:0][ADDR_W-1:0]     t_mem_addr;
  logic [NT-1:0][CMD_W-1:0]      t_mem_wdata;
  logic [NT-1:0]                 t_reg_req, t_reg_we, t_reg_fire;
  logic [NT-1:0][RADDR_W-1:0]    t_reg_addr;
  logic [NT-1:0][CMD_W-1:0]      t_reg_wdata;
  logic [NT-1:0]                 t_sig_we, t_sig_val;
  logic [NT-1:0][2:0]            t_sig_idx;
  logic [NT-1:0]                 m_gnt, r_gnt, m_req;
  logic [IW-1:0]                 m_sel, r_sel, rd_owner;
  logic                          m_any, r_any, rd_pend;

  seq_event_latch #(.W(EV_W)) u_ev (
    .clk(clk), .rst_n(rst_n), .ev_in(event_in), .ev_flag(ev_flag)
  );

  for (genvar i = 0; i < NT; i++) begin : g_task
    seq_task #(.AW(ADDR_W), .RAW(RADDR_W), .TW(TMO_W), .EV_W(EV_W)) u_task (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (task_start[i]),
      .start_addr(start_addr[i*ADDR_W +: ADDR_W]),
      .tmo_limit (tmo_limit[i*TMO_W +: TMO_W]),
      .ev_flag   (ev_flag),
      .sig_in    (sig_out),
      .mem_req   (t_mem_req[i]),
      .mem_we    (t_mem_we[i]),
      .mem_addr  (t_mem_addr[i]),
      .mem_wdata (t_mem_wdata[i]),
      .mem_fire  (t_mem_fire[i]),
      .rsp_valid (t_rsp[i]),
      .rsp_data  (mem_rdata),
      .reg_req   (t_reg_req[i]),
      .reg_we    (t_reg_we[i]),
      .reg_addr  (t_reg_addr[i]),
      .reg_wdata (t_reg_wdata[i]),
      .reg_fire  (t_reg_fire[i]),
      .reg_rdata (reg_rdata),
      .sig_we    (t_sig_we[i]),
      .sig_idx   (t_sig_idx[i]),
      .sig_val   (t_sig_val[i]),
      .en        (task_en[i]),
      .tmo_flag  (task_timeout[i])
    );
    assign t_mem_fire[i] = m_gnt[i] & mem_ready;
    assign t_reg_fire[i] = r_gnt[i] & reg_ready;
    assign t_rsp[i]      = mem_rvalid & rd_pend & (rd_owner == IW'(i));
  end

  assign m_req = t_mem_req & {NT{~rd_pend}};

  seq_rr_arb #(.N(NT)) u_marb (
    .clk(clk), .rst_n(rst_n), .req(m_req), .ready(mem_ready),
    .gnt(m_gnt), .sel(m_sel), .any(m_any)
  );

  seq_rr_arb #(.N(NT)) u_rarb (
    .clk(clk), .rst_n(rst_n), .req(t_reg_req), .ready(reg_ready),
    .gnt(r_gnt), .sel(r_sel), .any(r_any)
  );

  always_comb begin
    mem_valid = m_any;
    mem_write = t_mem_we[m_sel];
    mem_addr  = t_mem_addr[m_sel];
    mem_wdata = t_mem_wdata[m_sel];
    reg_valid = r_any;
    reg_write = t_reg_we[r_sel];
    reg_addr  = t_reg_addr[r_sel];
    reg_wdata = t_reg_wdata[r_sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      rd_owner <= '0;
    end else if (m_any && mem_ready && !mem_write) begin
      rd_pend  <= 1'b1;
      rd_owner <= m_sel;
    end else if (mem_rvalid) begin
      rd_pend  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_out <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (t_sig_we[i] && (int'(t_sig_idx[i]) < NUM_SIG))
          sig_out[t_sig_idx[i]] <= t_sig_val[i];
      end
    end
  end
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_TASKS-1:0] task_start,
  input logic [NUM_TASKS-1:0] task_en,
  input logic [NUM_TASKS-1:0] task_timeout,
  input logic                 mem_valid,
  input logic                 mem_ready,
  input logic                 mem_write,
  input logic [AW-1:0]        mem_addr,
  input logic [CMD_W-1:0]     mem_wdata,
  input logic                 reg_valid,
  input logic                 reg_ready,
  input logic                 reg_write,
  input logic [RAW-1:0]       reg_addr,
  input logic [CMD_W-1:0]     reg_wdata
);
  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_t
    p_start_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(task_en[i]) |-> $past(task_start[i]));
    p_tmo_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(task_timeout[i]) |-> $fell(task_en[i]));
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (task_en == '0) |-> (!mem_valid && !reg_valid));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata)));

  p_reg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr)
      && $stable(reg_write) && $stable(reg_wdata)));

  p_one_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write) |=> !mem_valid);
endmodule

bind dual_task_sequencer seq_checker #(.AW(ADDR_W), .RAW(RADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_en(task_en),
  .task_timeout(task_timeout), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/dual_task_sequencer_bench.sv
module dual_task_sequencer_bench;
  localparam int AW = 8, RAW = 4, TW = 8, EW = 4;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [1:0]      task_start = '0;
  logic [1:0][AW-1:0] st_addr = '0;
  logic [1:0][TW-1:0] st_lim = '0;
  logic [EW-1:0]   ev = 4'b0010;
  logic [1:0]      task_en, task_timeout;
  logic [4:0]      sig_out;
  logic            mem_valid, mem_ready, mem_write, mem_rvalid;
  logic [AW-1:0]   mem_addr;
  logic [31:0]     mem_wdata, mem_rdata;
  logic            reg_valid, reg_ready, reg_write;
  logic [RAW-1:0]  reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;

  logic [31:0] mem [256];
  logic [31:0] regs [16];
  logic        bp = 1'b0;
  logic [7:0]  lfsr;
  logic        pw_en = 1'b0, rw_en = 1'b0;
  logic [7:0]  pw_a = '0;
  logic [3:0]  rw_a = '0;
  logic [31:0] pw_d = '0, rw_d = '0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  dual_task_sequencer #(.ADDR_W(AW), .RADDR_W(RAW), .TMO_W(TW), .EV_W(EW))
  u_dual_task_sequencer (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .start_addr(st_addr),
    .tmo_limit(st_lim), .event_in(ev), .task_en(task_en),
    .task_timeout(task_timeout), .sig_out(sig_out), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk) begin
    lfsr       <= rst_n ? {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]} : 8'hA5;
    mem_ready  <= bp ? lfsr[0] : 1'b1;
    reg_ready  <= bp ? lfsr[3] : 1'b1;
    mem_rvalid <= 1'b0;
    if (pw_en) mem[pw_a] <= pw_d;
    if (rw_en) regs[rw_a] <= rw_d;
    if (mem_valid && mem_ready) begin
      if (mem_write) mem[mem_addr] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr];
      end
    end
    if (reg_valid && reg_ready && reg_write) regs[reg_addr] <= reg_wdata;
  end

  localparam logic [35:0] VEC [8] = '{
    {4'd0, 32'h0000_0001}, {4'd15, 32'hFFFF_FFFF}, {4'd9, 32'h8000_0000},
    {4'd2, 32'h1357_9BDF}, {4'd14, 32'h0000_0000}, {4'd1, 32'hCAFE_F00D},
    {4'd8, 32'h7FFF_FFFE}, {4'd10, 32'h0F0F_0F0F}
  };

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [5:0] cnd,
                                     input logic [15:0] lo);
    return {op, 6'd0, cnd, lo};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); pw_en = 1'b1; pw_a = a; pw_d = d;
    @(negedge clk); pw_en = 1'b0;
  endtask

  task automatic rp(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); rw_en = 1'b1; rw_a = a; rw_d = d;
    @(negedge clk); rw_en = 1'b0;
  endtask

  task automatic run(input int t, input logic [7:0] a, input logic [7:0] lim);
    @(negedge clk); st_addr[t] = a; st_lim[t] = lim; task_start[t] = 1'b1;
    @(negedge clk); task_start[t] = 1'b0;
  endtask

  task automatic wait_idle(input int t, input int lim);
    int n = 0;
    while (task_en[t] && n < lim) begin @(negedge clk); n++; end
    chk(n < lim, "R5 task returns to idle", 32'(n), 32'(lim));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(task_en == 2'b00, "R1 enables after reset", 32'(task_en), 0);
    chk(task_timeout == 2'b00 && sig_out == 5'd0, "R1 flags and signals",
        32'({task_timeout, sig_out}), 0);
    chk(!mem_valid && !reg_valid, "R1 no requests", 32'({mem_valid, reg_valid}), 0);

    // load vectors, with and without back-pressure (R3, R12)
    for (int v = 0; v < 8; v++) begin
      bp = v[0];
      wr(0, mk(4'd1, 6'd0, {12'd0, VEC[v][35:32]}));
      wr(1, VEC[v][31:0]);
      wr(2, mk(4'd0, 6'd0, 16'd0));
      run(0, 8'd0, 8'd0);
      wait_idle(0, 500);
      chk(regs[VEC[v][35:32]] == VEC[v][31:0], "R3 load writes register",
          regs[VEC[v][35:32]], VEC[v][31:0]);
      chk(task_en[0] == 1'b0, "R5 stop clears enable", 32'(task_en[0]), 0);
    end

    // unknown opcode skipped (R5)
    bp = 1'b0;
    rp(3, 32'd0);
    wr(16, 32'hF000_1234); wr(17, mk(4'd1, 6'd0, 16'd3));
    wr(18, 32'h0000_ABCD); wr(19, mk(4'd0, 6'd0, 16'd0));
    run(0, 8'd16, 8'd0); wait_idle(0, 500);
    chk(regs[3] == 32'h0000_ABCD, "R5 unknown opcode skipped", regs[3], 32'h0000_ABCD);

    // upload (R4)
    rp(7, 32'h1234_5678);
    wr(20, mk(4'd2, 6'd0, 16'd7)); wr(21, 32'd200); wr(22, mk(4'd0, 6'd0, 16'd0));
    run(1, 8'd20, 8'd0); wait_idle(1, 500);
    chk(mem[200] == 32'h1234_5678, "R4 upload to memory", mem[200], 32'h1234_5678);

    // shared signals (R9)
    wr(30, mk(4'd5, 6'd0, 16'h0102)); wr(31, mk(4'd5, 6'd0, 16'h0104));
    wr(32, mk(4'd5, 6'd0, 16'h0002)); wr(33, mk(4'd0, 6'd0, 16'd0));
    run(0, 8'd30, 8'd0); wait_idle(0, 500);
    chk(sig_out == 5'b10000, "R9 set and clear signals", 32'(sig_out), 32'h10);

    // jump taken and not taken (R8)
    rp(1, 32'd0); rp(2, 32'd0);
    wr(40, mk(4'd5, 6'd0, 16'h0103)); wr(41, mk(4'd4, 6'h23, 16'd46));
    wr(42, mk(4'd1, 6'd0, 16'd1)); wr(43, 32'h11); wr(44, mk(4'd0, 6'd0, 16'd0));
    wr(46, mk(4'd4, 6'h21, 16'd40)); wr(47, mk(4'd1, 6'd0, 16'd2));
    wr(48, 32'h22); wr(49, mk(4'd0, 6'd0, 16'd0));
    run(1, 8'd40, 8'd0); wait_idle(1, 500);
    chk(regs[1] == 32'd0, "R8 taken jump skips load", regs[1], 0);
    chk(regs[2] == 32'h22, "R8 untaken jump falls through", regs[2], 32'h22);

    // pause while the other task runs, with contention (R6, R11, R2)
    bp = 1'b1;
    rp(3, 32'd0); rp(4, 32'd0); rp(5, 32'd0); rp(6, 32'd0);
    wr(60, mk(4'd3, 6'd0, 16'd0)); wr(61, mk(4'd1, 6'd0, 16'd4));
    wr(62, 32'h44); wr(63, mk(4'd0, 6'd0, 16'd0));
    wr(70, mk(4'd1, 6'd0, 16'd5)); wr(71, 32'h55); wr(72, mk(4'd1, 6'd0, 16'd6));
    wr(73, 32'h66); wr(74, mk(4'd0, 6'd0, 16'd0));
    @(negedge clk);
    st_addr[0] = 8'd60; st_addr[1] = 8'd70; st_lim = '0; task_start = 2'b11;
    @(negedge clk); task_start = 2'b00;
    wait_idle(1, 1000);
    chk(task_en[0] == 1'b1, "R6 paused task stays enabled", 32'(task_en[0]), 1);
    chk(regs[4] == 32'd0, "R6 paused task holds", regs[4], 0);
    chk(regs[5] == 32'h55 && regs[6] == 32'h66, "R11 other task completes",
        regs[6], 32'h66);
    run(0, 8'd16, 8'd0);
    @(negedge clk); ev[0] = 1'b1;
    wait_idle(0, 1000);
    chk(regs[4] == 32'h44, "R6 resumes on event", regs[4], 32'h44);
    chk(regs[3] == 32'd0, "R2 start while running ignored", regs[3], 0);
    bp = 1'b0;

    // event high from reset never rises: timeout (R7, R10)
    wr(80, mk(4'd3, 6'd1, 16'd0)); wr(81, mk(4'd0, 6'd0, 16'd0));
    run(1, 8'd80, 8'd20);
    repeat (10) @(negedge clk);
    chk(task_en[1] == 1'b1, "R10 no early abort", 32'(task_en[1]), 1);
    wait_idle(1, 100);
    chk(task_timeout[1] == 1'b1, "R7 level from reset not an event",
        32'(task_timeout[1]), 1);
    chk(task_timeout[0] == 1'b0, "R10 other flag untouched", 32'(task_timeout[0]), 0);
    @(negedge clk); ev[1] = 1'b0;
    @(negedge clk); ev[1] = 1'b1;
    repeat (2) @(negedge clk);
    run(1, 8'd80, 8'd20);
    chk(task_timeout[1] == 1'b0, "R2 start clears timeout flag",
        32'(task_timeout[1]), 0);
    wait_idle(1, 100);
    chk(task_timeout[1] == 1'b0, "R7 rising edge releases pause",
        32'(task_timeout[1]), 0);

    // limit 0 never times out (R10)
    wr(90, mk(4'd3, 6'd2, 16'd0)); wr(91, mk(4'd0, 6'd0, 16'd0));
    run(0, 8'd90, 8'd0);
    repeat (300) @(negedge clk);
    chk(task_en[0] == 1'b1 && task_timeout[0] == 1'b0, "R10 zero limit waits",
        32'({task_en[0], task_timeout[0]}), 32'h2);
    @(negedge clk); ev[2] = 1'b1;
    wait_idle(0, 100);
    chk(task_timeout[0] == 1'b0, "R10 zero limit ends cleanly",
        32'(task_timeout[0]), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule